// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block lets on-chip logic use a small three-wire serial EEPROM organised as 64 words of 16 bits. A client places one request on a simple command port: an operation code, a word address and, for writes, a data word. The controller then runs the whole serial transaction. It raises chip select, sends a start bit, a two-bit opcode and an address field, moves the data, and lowers chip select. A one-cycle done pulse returns the read data and an error flag.

The serial clock is derived from the system clock. Each bit lasts `2*HALF_DIV` system cycles. The controller changes data-in only while the serial clock is low and samples data-out on its rising edge. Write, erase and erase-all commands are committed by the device when chip select falls. After such a command the controller keeps chip select low for one serial period. It then raises chip select again and keeps clocking until data-out reads high, which means the device's self-timed programming cycle has finished. If that never happens within `POLL_LIMIT` system cycles, the transaction ends with the error flag set.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: After synchronous reset, ee_cs, ee_sck, ee_di, rsp_done and rsp_err are 0 and req_ready is 1.
- R2: Each frame bit is held on ee_di for one full serial period of 2*HALF_DIV system cycles. Rising serial edges within one chip-select session are exactly 2*HALF_DIV cycles apart, and ee_di never changes while ee_sck is high.
- R3: Every frame starts with a 1, then a 2-bit opcode and a 6-bit address field, each MSB first. The opcodes are read=10, write=01, erase=11 and special=00. For specials the address field is 110000 for write-enable, 000000 for write-disable and 100000 for erase-all. Request codes on req_op are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-enable and 5 write-disable.
- R4: A write frame carries the 16 data bits MSB first after the address, for 25 bits in total. Chip select falls in the same cycle as the serial clock falls after the last bit.
- R5: A read frame is followed by 17 further rising edges with ee_di held at 0. The first sampled bit is discarded, and the next 16 bits, MSB first, are returned on rsp_rdata with the done pulse.
- R6: Write, erase and erase-all are followed by a polling session. Chip select is raised again with the serial clock running, and the session ends after the first rising-edge sample of ee_do that reads 1. Read, write-enable and write-disable finish without polling.
- R7: If ee_do is not seen high within POLL_LIMIT system cycles of polling, the transaction ends with rsp_err=1.
- R8: Chip select stays low for at least one serial period (2*HALF_DIV cycles) between any two chip-select sessions and before the done pulse.
- R9: A request is taken only while req_ready is 1. req_valid asserted during a transaction starts no frame and changes no memory word.
- R10: rsp_done is a single-cycle pulse, and rsp_err is 0 for a completed legal operation. Request codes 6 and 7 produce a done pulse with rsp_err=1 and no chip-select activity.
- R11: ee_sck is high only while ee_cs is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_op | input | 3 | Operation code (see R3) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data word for write |
| req_ready | output | 1 | Controller idle, able to take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done after a read |
| rsp_err | output | 1 | Error flag, valid with rsp_done |
| ee_cs | output | 1 | Chip select to the EEPROM, active high |
| ee_sck | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
The checker watches four things on every cycle: the serial clock stays gated by chip select, data-in is stable while the clock is high, done is a single pulse, and the port is busy while chip select is up. It also counts cycles to confirm the minimum chip-select low time before each new session and confirms that chip select never falls with the clock high. Only the bench's device model can show the frame contents: opcodes, address and data order, the dropped dummy read bit, the commit on the chip-select fall, the point at which polling ends, timeout behaviour, and that a request made while busy is lost. The bench shows these by writing and reading back every address and by running targeted erase, protect and stuck-busy cases.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_ERAL  = 3'd3,
    OP_WREN  = 3'd4,
    OP_WRDIS = 3'd5
  } uw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_RECV,
    ST_GAP,
    ST_POLL
  } uw_state_e;

endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !en)                     phase <= '0;
    else if (phase == PW'(PERIOD - 1))  phase <= '0;
    else                                phase <= phase + 1'b1;
  end

  assign rise_stb = en && (phase == PW'(HALF_DIV - 1));
  assign fall_stb = en && (phase == PW'(PERIOD - 1));
endmodule

// File: rtl/uwire_framer.sv
module uwire_framer
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic [2:0]                              op,
  input  logic [ADDR_W-1:0]                       addr,
  input  logic [DATA_W-1:0]                       wdata,
  output logic [3+ADDR_W+DATA_W-1:0]              frame,
  output logic [$clog2(3+ADDR_W+DATA_W+1)-1:0]    nbits,
  output logic                                    prog,
  output logic                                    is_read,
  output logic                                    valid
);
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int NBW     = $clog2(FRAME_W + 1);

  logic [1:0]        opc;
  logic [ADDR_W-1:0] fld;
  logic              has_data;

  always_comb begin
    opc      = 2'b00;
    fld      = '0;
    nbits    = NBW'(HDR_W);
    prog     = 1'b0;
    is_read  = 1'b0;
    valid    = 1'b1;
    has_data = 1'b0;
    case (op)
      OP_READ:  begin opc = 2'b10; fld = addr; is_read = 1'b1; end
      OP_WRITE: begin opc = 2'b01; fld = addr; prog = 1'b1; has_data = 1'b1;
                      nbits = NBW'(FRAME_W); end
      OP_ERASE: begin opc = 2'b11; fld = addr; prog = 1'b1; end
      OP_ERAL:  begin fld = {2'b10, {(ADDR_W-2){1'b0}}}; prog = 1'b1; end
      OP_WREN:  begin fld = {2'b11, {(ADDR_W-2){1'b0}}}; end
      OP_WRDIS: begin fld = '0; end
      default:  valid = 1'b0;
    endcase
    frame = {1'b1, opc, fld, has_data ? wdata : {DATA_W{1'b0}}};
  end
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
module uwire_eeprom_ctrl
  import uwire_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int HALF_DIV   = 4,
  parameter int POLL_LIMIT = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              ee_cs,
  output logic              ee_sck,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int BCW     = $clog2(FRAME_W + 1);
  localparam int RCW     = $clog2(DATA_W + 1);
  localparam int TCW     = $clog2(POLL_LIMIT + 1);

  uw_state_e          state;
  logic [FRAME_W-1:0] frame_sh;
  logic [BCW-1:0]     bits_left;
  logic [RCW-1:0]     rd_cnt;
  logic [DATA_W-1:0]  rd_sh;
  logic [TCW-1:0]     tmo_cnt;
  logic               is_read_q, prog_q, polled_q, err_q, rdy_q;
  logic               rise_stb, fall_stb;

  logic [FRAME_W-1:0] f_frame;
  logic [BCW-1:0]     f_nbits;
  logic               f_prog, f_read, f_valid;

  uwire_tick #(.HALF_DIV(HALF_DIV)) tick_i (
    .clk(clk), .rst(rst), .en(state != ST_IDLE),
    .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  uwire_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) framer_i (
    .op(req_op), .addr(req_addr), .wdata(req_wdata),
    .frame(f_frame), .nbits(f_nbits), .prog(f_prog),
    .is_read(f_read), .valid(f_valid)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      frame_sh  <= '0;
      bits_left <= '0;
      rd_cnt    <= '0;
      rd_sh     <= '0;
      tmo_cnt   <= '0;
      is_read_q <= 1'b0;
      prog_q    <= 1'b0;
      polled_q  <= 1'b0;
      err_q     <= 1'b0;
      rdy_q     <= 1'b0;
      ee_cs     <= 1'b0;
      ee_sck    <= 1'b0;
      ee_di     <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          if (!f_valid) begin
            rsp_done <= 1'b1;
            rsp_err  <= 1'b1;
          end else begin
            frame_sh  <= f_frame;
            bits_left <= f_nbits;
            is_read_q <= f_read;
            prog_q    <= f_prog;
            polled_q  <= 1'b0;
            err_q     <= 1'b0;
            ee_cs     <= 1'b1;
            ee_sck    <= 1'b0;
            ee_di     <= f_frame[FRAME_W-1];
            state     <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (rise_stb) ee_sck <= 1'b1;
          if (fall_stb) begin
            ee_sck    <= 1'b0;
            frame_sh  <= frame_sh << 1;
            bits_left <= bits_left - 1'b1;
            if (bits_left == BCW'(1)) begin
              ee_di <= 1'b0;
              if (is_read_q) begin
                rd_cnt <= '0;
                state  <= ST_RECV;
              end else begin
                ee_cs <= 1'b0;
                state <= ST_GAP;
              end
            end else begin
              ee_di <= frame_sh[FRAME_W-2];
            end
          end
        end
        ST_RECV: begin
          if (rise_stb) begin
            ee_sck <= 1'b1;
            if (rd_cnt != '0) rd_sh <= {rd_sh[DATA_W-2:0], ee_do};
          end
          if (fall_stb) begin
            ee_sck <= 1'b0;
            rd_cnt <= rd_cnt + 1'b1;
            if (rd_cnt == RCW'(DATA_W)) begin
              ee_cs <= 1'b0;
              state <= ST_GAP;
            end
          end
        end
        ST_GAP: if (fall_stb) begin
          if (prog_q && !polled_q) begin
            polled_q <= 1'b1;
            rdy_q    <= 1'b0;
            tmo_cnt  <= '0;
            ee_cs    <= 1'b1;
            state    <= ST_POLL;
          end else begin
            rsp_done <= 1'b1;
            rsp_err  <= err_q;
            if (is_read_q) rsp_rdata <= rd_sh;
            state    <= ST_IDLE;
          end
        end
        ST_POLL: begin
          if (tmo_cnt != TCW'(POLL_LIMIT)) tmo_cnt <= tmo_cnt + 1'b1;
          if (rise_stb) begin
            ee_sck <= 1'b1;
            rdy_q  <= ee_do;
          end
          if (fall_stb) begin
            ee_sck <= 1'b0;
            if (rdy_q) begin
              ee_cs <= 1'b0;
              state <= ST_GAP;
            end else if (tmo_cnt == TCW'(POLL_LIMIT)) begin
              err_q <= 1'b1;
              ee_cs <= 1'b0;
              state <= ST_GAP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwire_eeprom_ctrl_chk.sv
module uwire_eeprom_ctrl_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_done,
  input logic ee_cs,
  input logic ee_sck,
  input logic ee_di
);
  localparam int GAP = 2 * HALF_DIV;
  localparam int GW  = $clog2(GAP + 1) + 1;

  logic [GW-1:0] low_cnt;
  logic          seen_cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      seen_cs <= 1'b0;
    end else begin
      if (ee_cs)                     low_cnt <= '0;
      else if (low_cnt != GW'(GAP))  low_cnt <= low_cnt + 1'b1;
      if (ee_cs) seen_cs <= 1'b1;
    end
  end

  // R11
  sck_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ee_sck |-> ee_cs);

  // R2
  di_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ee_sck && $past(ee_sck)) |-> $stable(ee_di));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R9
  busy_port_chk: assert property (@(posedge clk) disable iff (rst)
    ee_cs |-> !req_ready);

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_cs && $rose(ee_cs)) |-> (low_cnt >= GW'(GAP)));

  // R4
  cs_drop_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ee_cs) |-> !ee_sck);
endmodule

bind uwire_eeprom_ctrl uwire_eeprom_ctrl_chk #(.HALF_DIV(HALF_DIV)) chk_i (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
  .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_di(ee_di)
);

// File: tb/uwire_eeprom_ctrl_tb.sv
`timescale 1ns/1ps
module uwire_eeprom_ctrl_tb_top;
  import uwire_pkg::*;

  localparam int HALF  = 2;
  localparam int PLIM  = 300;
  localparam int BUSY  = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic        ee_cs, ee_sck, ee_di;
  logic        ee_do = 1'b0;

  always #4 clk = ~clk;

  uwire_eeprom_ctrl #(.ADDR_W(6), .DATA_W(16), .HALF_DIV(HALF), .POLL_LIMIT(PLIM)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_di(ee_di), .ee_do(ee_do)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- device model and monitor ----------------
  logic [15:0] mem [0:63];
  logic        wen = 1'b0, polling = 1'b0, in_poll = 1'b0, stuck = 1'b0;
  logic        pcs = 1'b0, psck = 1'b0, pdi = 1'b0;
  logic [24:0] sh = '0, last_frame = '0;
  logic [8:0]  hdr = '0, last_hdr = '0;
  int nbits = 0, last_nbits = 0, busy = 0, frames = 0, polls = 0, cs_rises = 0;
  int cyc = 0, last_rise = -1, fall_cyc = -1, min_gap = 1000000;
  int viol_period = 0, viol_di = 0, viol_sck = 0;

  always @(negedge clk) begin
    if (rst) begin
      pcs = 1'b0; psck = 1'b0; pdi = 1'b0;
    end else begin
      cyc++;
      if (busy > 0) busy--;
      if (ee_sck && !ee_cs) viol_sck++;
      if (ee_sck && psck && (ee_di != pdi)) viol_di++;
      if (ee_cs && !pcs) begin
        cs_rises++;
        if (fall_cyc >= 0 && (cyc - fall_cyc) < min_gap) min_gap = cyc - fall_cyc;
        nbits = 0; sh = '0; last_rise = -1; in_poll = polling;
        if (polling) polls++;
      end
      if (ee_cs && ee_sck && !psck) begin
        if (last_rise >= 0 && (cyc - last_rise) != 2*HALF) viol_period++;
        last_rise = cyc;
        if (!in_poll) begin
          sh = {sh[23:0], ee_di};
          nbits++;
          if (nbits == 9) hdr = sh[8:0];
        end
      end
      if (ee_cs && !ee_sck && psck && !in_poll && nbits >= 9 && hdr[7:6] == 2'b10) begin
        if (nbits == 9) ee_do = 1'b0;
        else if (nbits <= 25) ee_do = mem[hdr[5:0]][25 - nbits];
      end
      if (in_poll && ee_cs) ee_do = (busy == 0) && !stuck;
      if (!ee_cs && pcs) begin
        fall_cyc = cyc;
        ee_do = 1'b0;
        if (in_poll) begin
          in_poll = 1'b0; polling = 1'b0;
        end else begin
          frames++; last_frame = sh; last_nbits = nbits; last_hdr = hdr;
          if (nbits == 25 && sh[23:22] == 2'b01) begin
            polling = 1'b1;
            if (wen) begin mem[sh[21:16]] = sh[15:0]; busy = BUSY; end
          end else if (nbits == 9 && sh[7:6] == 2'b11) begin
            polling = 1'b1;
            if (wen) begin mem[sh[5:0]] = 16'hFFFF; busy = BUSY; end
          end else if (nbits == 9 && sh[7:6] == 2'b00) begin
            case (sh[5:4])
              2'b11: wen = 1'b1;
              2'b00: wen = 1'b0;
              2'b10: begin
                polling = 1'b1;
                if (wen) begin
                  for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                  busy = BUSY;
                end
              end
              default: ;
            endcase
          end
        end
      end
      pcs = ee_cs; psck = ee_sck; pdi = ee_di;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h0403) ^ 16'hA5C3;
  endfunction

  function automatic logic [8:0] exp_hdr(input logic [2:0] op, input logic [5:0] a);
    case (op)
      OP_READ:  return {1'b1, 2'b10, a};
      OP_WRITE: return {1'b1, 2'b01, a};
      OP_ERASE: return {1'b1, 2'b11, a};
      OP_ERAL:  return {1'b1, 2'b00, 6'b100000};
      OP_WREN:  return {1'b1, 2'b00, 6'b110000};
      default:  return {1'b1, 2'b00, 6'b000000};
    endcase
  endfunction

  logic [15:0] rd_v;
  logic        err_v;

  task automatic start_op(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input bit framed);
    while (!rsp_done) @(negedge clk);
    rd_v = rsp_rdata; err_v = rsp_err;
    if (framed) chk((cyc + 1 - fall_cyc) >= 2*HALF, "R8 gap before done", cyc + 1 - fall_cyc, 2*HALF);
    @(negedge clk);
    chk(!rsp_done, "R10 done pulse width", rsp_done, 0);
    #1;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d);
    int p0;
    p0 = polls;
    start_op(op, a, d);
    wait_done(1'b1);
    chk(last_hdr == exp_hdr(op, a), "R3 frame header", last_hdr, exp_hdr(op, a));
    if (op == OP_WRITE || op == OP_ERASE || op == OP_ERAL)
      chk(polls == p0 + 1, "R6 poll session after programming", polls, p0 + 1);
    else
      chk(polls == p0, "R6 no poll for non-programming op", polls, p0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int f0, c0;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ee_cs == 0 && ee_sck == 0 && ee_di == 0, "R1 serial pins at reset", {ee_cs, ee_sck, ee_di}, 0);
    chk(req_ready == 1 && rsp_done == 0 && rsp_err == 0, "R1 port at reset",
        {req_ready, rsp_done, rsp_err}, 3'b100);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    run_op(OP_WREN, 6'd0, 16'd0);
    chk(err_v == 0, "R10 write-enable no error", err_v, 0);

    // R4 write sweep over every address
    for (int a = 0; a < 64; a++) begin
      run_op(OP_WRITE, 6'(a), pat(a));
      chk(err_v == 0 && busy == 0, "R6 write done after ready", {err_v, 8'(busy)}, 0);
      chk(last_nbits == 25 && last_frame[15:0] == pat(a), "R4 write data bits",
          last_frame[15:0], pat(a));
    end
    // R5 read sweep
    for (int a = 0; a < 64; a++) begin
      run_op(OP_READ, 6'(a), 16'd0);
      chk(rd_v == pat(a) && err_v == 0, "R5 read data", rd_v, pat(a));
      chk(last_nbits == 26 && last_frame[16:0] == 17'd0, "R5 read tail length and di low",
          last_nbits, 26);
    end

    run_op(OP_ERASE, 6'd7, 16'd0);
    run_op(OP_READ, 6'd7, 16'd0);
    chk(rd_v == 16'hFFFF, "R3 erase cleared word", rd_v, 16'hFFFF);
    run_op(OP_READ, 6'd8, 16'd0);
    chk(rd_v == pat(8), "R3 erase left neighbour", rd_v, pat(8));

    // R9 request while busy is dropped
    f0 = frames;
    start_op(OP_READ, 6'd3, 16'd0);
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_op = OP_WRITE; req_addr = 6'd3; req_wdata = 16'h0000;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    wait_done(1'b1);
    chk(rd_v == pat(3), "R9 read during busy request", rd_v, pat(3));
    repeat (40) @(negedge clk);
    chk(frames == f0 + 1, "R9 no extra frame", frames, f0 + 1);
    run_op(OP_READ, 6'd3, 16'd0);
    chk(rd_v == pat(3), "R9 word untouched", rd_v, pat(3));

    // write-disable then attempted write
    run_op(OP_WRDIS, 6'd0, 16'd0);
    run_op(OP_WRITE, 6'd9, 16'h1234);
    run_op(OP_READ, 6'd9, 16'd0);
    chk(rd_v == pat(9), "R3 write-disable protects", rd_v, pat(9));

    // R10 illegal codes
    for (int k = 6; k < 8; k++) begin
      c0 = cs_rises;
      start_op(3'(k), 6'd0, 16'd0);
      wait_done(1'b0);
      chk(err_v == 1, "R10 illegal code error", err_v, 1);
      chk(cs_rises == c0, "R10 illegal code no cs", cs_rises, c0);
    end

    // R7 timeout
    run_op(OP_WREN, 6'd0, 16'd0);
    stuck = 1'b1;
    run_op(OP_WRITE, 6'd10, 16'hBEEF);
    chk(err_v == 1, "R7 timeout error", err_v, 1);
    stuck = 1'b0;
    run_op(OP_WRITE, 6'd11, 16'h5A5A);
    chk(err_v == 0, "R7 error cleared on next op", err_v, 0);

    // erase-all
    run_op(OP_ERAL, 6'd0, 16'd0);
    for (int a = 0; a < 64; a += 21) begin
      run_op(OP_READ, 6'(a), 16'd0);
      chk(rd_v == 16'hFFFF, "R3 erase-all word", rd_v, 16'hFFFF);
    end

    chk(viol_period == 0, "R2 serial period", viol_period, 0);
    chk(viol_di == 0, "R2 di stable while sck high", viol_di, 0);
    chk(viol_sck == 0, "R11 sck only with cs", viol_sck, 0);
    chk(min_gap >= 2*HALF, "R8 minimum cs low time", min_gap, 2*HALF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule